// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Register

This block holds the interrupt status of a real-time-clock peripheral. Three single-clock event pulses come in: periodic tick, alarm match and update-ended. Each pulse sets a sticky flag. Three enable bits come from the peripheral's control register. The block drives an active-low interrupt line whenever a flag and its enable are both set, and it returns a status byte when software reads the register.

A read lasts as long as a strobe stays high, which may be one clock or many. When the strobe rises, the block captures the status byte, and that value does not change for the rest of the access. When the strobe falls, every flag is cleared. Events that arrived during the access are held in a pending register while the strobe is high. They are merged into the flags as the read ends, so no event is lost.

Top module: `rtc_irq_status`

## Requirements
- R1: The status byte places the periodic flag at bit 6, the alarm flag at bit 5, the update-ended flag at bit 4 and the interrupt summary at bit 7. Bits 3..0 always read 0.
- R2: An event pulse seen while `rd_strobe` is low sets its flag on that clock, whatever the state of its enable bit.
- R3: `irq_n` is low exactly while at least one source has both its flag and its enable set, and it is high otherwise.
- R4: The summary bit of a captured byte is 1 exactly when `irq_n` was low in the clock where the strobe was first sampled high.
- R5: At the end of a read (the first clock where `rd_strobe` is low after being high), every flag is cleared, along with the summary bit that depends on them, except flags that events re-set under R7 or R8.
- R6: `rd_data` takes the status byte from the clock where `rd_strobe` is first sampled high and shows it from the next clock on. It holds that value until the next read starts.
- R7: Events that arrive while `rd_strobe` is high leave the flags unchanged during the read. They set their flags at the end of the read.
- R8: An event in the clock that ends the read sets its flag and is not cleared.
- R9: One captured byte can show one, two or all three flags at once.
- R10: While `rst_n` is low at a clock edge, all flags and pending events are cleared, `irq_n` goes high and `rd_data` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| rd_strobe | input | 1 | High for the length of a status read |
| rd_data | output | 8 | Captured status byte |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
On every clock, the assertions check four things:
- a pulse outside a read sets its flag;
- the flags hold steady while the strobe is high;
- only pending or same-clock events survive the end of a read;
- the captured summary bit matches the interrupt line at capture time.

Stability of the returned byte across a long read is also checked every cycle. Other behaviours can only be shown by the bench's scenarios:
- that an event deferred during a read reaches software on the next read;
- that an event in the closing clock is kept;
- that several flags show up together;
- that enables gate only the interrupt line and not the flags.

// File: rtl/rtc_irq_status.sv
module rtc_irq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_periodic,
  input  logic       ev_alarm,
  input  logic       ev_update,
  input  logic       en_periodic,
  input  logic       en_alarm,
  input  logic       en_update,
  input  logic       rd_strobe,
  output logic [7:0] rd_data,
  output logic       irq_n
);
  localparam int NSRC = 3;
  localparam int PADW = 8 - NSRC - 1;

  logic [NSRC-1:0] ev, en, flags, pend;
  logic            strobe_q, irq, rd_start, rd_end;
  logic [7:0]      snap;

  assign ev       = {ev_periodic, ev_alarm, ev_update};
  assign en       = {en_periodic, en_alarm, en_update};
  assign irq      = |(flags & en);
  assign irq_n    = ~irq;
  assign rd_data  = snap;
  assign rd_start = rd_strobe & ~strobe_q;
  assign rd_end   = ~rd_strobe & strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= '0;
      pend     <= '0;
      strobe_q <= 1'b0;
      snap     <= '0;
    end else begin
      strobe_q <= rd_strobe;
      if (rd_start) snap <= {irq, flags, {PADW{1'b0}}};
      if (rd_strobe) begin
        pend <= pend | ev;
      end else if (rd_end) begin
        flags <= pend | ev;
        pend  <= '0;
      end else begin
        flags <= flags | ev;
      end
    end
  end
endmodule

module rtc_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_periodic,
  input logic       ev_alarm,
  input logic       ev_update,
  input logic       rd_strobe,
  input logic [7:0] rd_data,
  input logic       irq_n,
  input logic [2:0] flags,
  input logic [2:0] pend
);
  logic [2:0] evv;
  assign evv = {ev_periodic, ev_alarm, ev_update};

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> ((flags & $past(evv)) == $past(evv)));

  assert_hold_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (flags == $past(flags)));

  assert_clear_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe && $past(rd_strobe)) |=> ((flags & ~($past(evv) | $past(pend))) == 3'b000));

  assert_summary_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !$past(rd_strobe)) |=> (rd_data[7] == !$past(irq_n)));

  assert_snap_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && $past(rd_strobe) && $past(rd_strobe, 2)) |-> $stable(rd_data));
endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_periodic(ev_periodic), .ev_alarm(ev_alarm),
  .ev_update(ev_update), .rd_strobe(rd_strobe), .rd_data(rd_data),
  .irq_n(irq_n), .flags(flags), .pend(pend)
);

// File: tb/sim_rtc_irq_status.sv
`timescale 1ns/1ps
module sim_rtc_irq_status;
  logic clk = 0, rst_n = 0;
  logic ev_p = 0, ev_a = 0, ev_u = 0, en_p = 0, en_a = 0, en_u = 0, rd = 0;
  logic [7:0] rd_data;
  logic irq_n;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  rtc_irq_status u0 (.clk(clk), .rst_n(rst_n), .ev_periodic(ev_p), .ev_alarm(ev_a),
    .ev_update(ev_u), .en_periodic(en_p), .en_alarm(en_a), .en_update(en_u),
    .rd_strobe(rd), .rd_data(rd_data), .irq_n(irq_n));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: flag set / pending set / captured byte
  bit m_p, m_a, m_u, q_p, q_a, q_u, m_prev;
  logic [7:0] m_snap;
  function automatic bit m_irq();
    return (m_p && en_p) || (m_a && en_a) || (m_u && en_u);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      {m_p, m_a, m_u, q_p, q_a, q_u, m_prev} = '0;
      m_snap = 8'h00;
    end else begin
      if (rd && !m_prev) m_snap = {m_irq(), m_p, m_a, m_u, 4'h0};
      if (rd) begin
        q_p |= ev_p; q_a |= ev_a; q_u |= ev_u;
      end else if (m_prev) begin
        m_p = q_p | ev_p; m_a = q_a | ev_a; m_u = q_u | ev_u;
        {q_p, q_a, q_u} = '0;
      end else begin
        m_p |= ev_p; m_a |= ev_a; m_u |= ev_u;
      end
      m_prev = rd;
    end
    #5;
    chk("R3 irq_n", {7'h0, irq_n}, {7'h0, !m_irq()});
    chk("R6 rd_data", rd_data, m_snap);
  end

  task automatic read(int len, logic [7:0] exp, string req);
    rd = 1;
    @(negedge clk);
    chk(req, rd_data, exp);
    repeat (len - 1) @(negedge clk);
    rd = 0;
    @(negedge clk);
  endtask

  task automatic pulse(bit p, bit a, bit u);
    {ev_p, ev_a, ev_u} = {p, a, u};
    @(negedge clk);
    {ev_p, ev_a, ev_u} = 3'b000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset rd_data", rd_data, 8'h00);
    chk("R10 reset irq_n", {7'h0, irq_n}, 8'h01);
    rst_n = 1;
    @(negedge clk);
    // R2 polling with enables off, R1 layout
    pulse(0, 1, 0);
    @(negedge clk);
    chk("R2 irq_n stays high, enables off", {7'h0, irq_n}, 8'h01);
    read(1, 8'h20, "R1 R2 alarm flag at bit5");
    read(1, 8'h00, "R5 flags cleared by read");
    // R3 enable gating, R4 summary, R9 multiple flags
    en_p = 1;
    pulse(1, 0, 1);
    @(negedge clk);
    chk("R3 irq_n low", {7'h0, irq_n}, 8'h00);
    read(3, 8'hD0, "R4 R9 periodic+update with summary");
    chk("R5 irq_n released", {7'h0, irq_n}, 8'h01);
    pulse(1, 1, 1);
    read(2, 8'hF0, "R9 three flags");
    // R7 event during read deferred
    en_p = 0; en_a = 1;
    rd = 1;
    @(negedge clk);
    chk("R6 capture empty", rd_data, 8'h00);
    pulse(0, 1, 0);
    chk("R7 irq_n high during read", {7'h0, irq_n}, 8'h01);
    repeat (2) @(negedge clk);
    chk("R6 stable over long read", rd_data, 8'h00);
    rd = 0;
    @(negedge clk);
    chk("R7 deferred alarm raises irq", {7'h0, irq_n}, 8'h00);
    read(1, 8'hA0, "R7 deferred alarm visible");
    // R8 event in closing clock
    rd = 1;
    @(negedge clk);
    @(negedge clk);
    rd = 0; ev_u = 1;
    @(negedge clk);
    ev_u = 0;
    read(1, 8'h10, "R8 closing-clock update kept");
    // R10 reset mid-activity
    en_u = 1;
    pulse(0, 0, 1);
    rst_n = 0;
    @(negedge clk);
    chk("R10 reset releases irq_n", {7'h0, irq_n}, 8'h01);
    rst_n = 1;
    read(1, 8'h00, "R10 flags cleared by reset");
    // random traffic checked each clock by model
    for (int i = 0; i < 3000; i++) begin
      ev_p = ($urandom % 8) == 0;
      ev_a = ($urandom % 10) == 0;
      ev_u = ($urandom % 9) == 0;
      if (($urandom % 16) == 0) {en_p, en_a, en_u} = 3'($urandom);
      if (($urandom % 5) == 0) rd = ~rd;
      @(negedge clk);
    end
    {ev_p, ev_a, ev_u, rd} = '0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule